// File: doc/BRIEF.md
# Two-Channel Result Packet Sender

This block turns one latched search result into a short outgoing packet that is split over two linked AXI4-Stream channels. A result is a 10-bit start index and an 11-bit span length. A one-cycle request carries it in, together with a 64-bit header word. The block first presents the header on a context channel and then the result on a payload channel. Context always leaves before payload, so a downstream framer can join the two channels into one bus packet.

Each channel has its own valid/ready handshake, and either consumer may stall as long as it likes. The header and the result are captured when a request is accepted, so the source may change its inputs on the next cycle. A request that arrives while a packet is in flight is parked in a single pending slot. It is sent right after the current packet's cleanup cycle. A further request that arrives while the slot is full replaces the parked one.

Top module: `result_pkt_tx`

## Requirements
- R1: While reset is held, and on the first cycle after it, `ctx_tvalid` and `pld_tvalid` are both low.
- R2: A request accepted while idle raises `ctx_tvalid` on the next cycle. In that cycle `ctx_tdata` equals the captured header, `ctx_tlast` is 1, `ctx_tuser` is 0 and `pld_tvalid` is 0. The two valids are never high together.
- R3: `ctx_tvalid` stays high with `ctx_tdata` unchanged until a cycle in which `ctx_tready` is high.
- R4: In the cycle after the context handshake, `ctx_tvalid` is low and `pld_tvalid` is high. In that cycle `pld_tlast` is 1 and `pld_tdata` = {11'b0, start[9:0], size[10:0]}: the size sits in bits 10:0, the start in bits 20:11, and bits 31:21 are zero.
- R5: `pld_tvalid` stays high with `pld_tdata` unchanged until a cycle in which `pld_tready` is high.
- R6: After the payload handshake there is exactly one cleanup cycle in which both valids are low. The next header can appear no sooner than the cycle after it.
- R7: With both consumers always ready, the payload handshake falls on the second rising edge after the edge that accepts the request. That is the third edge when the accepting edge is counted as the first.
- R8: A request made while a packet is in progress is neither lost nor mixed into the current packet. It is sent after cleanup with the values it carried. If several requests arrive during one packet, only the last of them is sent.
- R9: Changing `snd_hdr`, `snd_start` or `snd_size` after a request has been accepted has no effect on that request's packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| snd_req | input | 1 | One-cycle send request |
| snd_hdr | input | 64 | Header word to send on the context channel |
| snd_start | input | 10 | Start index of the result |
| snd_size | input | 11 | Span length of the result |
| ctx_tdata | output | 64 | Context channel data (header) |
| ctx_tvalid | output | 1 | Context channel valid |
| ctx_tlast | output | 1 | Context channel last, high with every header |
| ctx_tuser | output | 2 | Context word type, always 0 for a header |
| ctx_tready | input | 1 | Context channel ready |
| pld_tdata | output | 32 | Payload channel data (packed result) |
| pld_tvalid | output | 1 | Payload channel valid |
| pld_tlast | output | 1 | Payload channel last |
| pld_tready | input | 1 | Payload channel ready |

## Verification
The assertions check the per-cycle handshake rules on every cycle:
- each valid holds with stable data through a stall;
- the two valids are never high together;
- the payload only rises after a context handshake;
- a cleanup gap follows each payload handshake;
- a parked request is not lost before cleanup.

Only the bench's scenarios can show that the data values are right end to end. That covers packet order and the exact latency with ready consumers. It also covers requests that replace a parked one and inputs that change after acceptance. A scoreboard compares every word that leaves the block against values the bench computes from the request stream.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DAT  = 2'd2,
    ST_CLN  = 2'd3
  } rpt_state_e;

  // next state of the send sequence
  function automatic rpt_state_e rpt_next(input rpt_state_e cur,
                                          input logic launch,
                                          input logic c_hs,
                                          input logic p_hs);
    rpt_state_e nx;
    nx = cur;
    case (cur)
      ST_IDLE: if (launch) nx = ST_HDR;
      ST_HDR:  if (c_hs)   nx = ST_DAT;
      ST_DAT:  if (p_hs)   nx = ST_CLN;
      ST_CLN:  nx = launch ? ST_HDR : ST_IDLE;
      default: nx = ST_IDLE;
    endcase
    return nx;
  endfunction

endpackage

// File: rtl/rpt_slot.sv
module rpt_slot #(
  parameter int HDR_W   = 64,
  parameter int START_W = 10,
  parameter int SIZE_W  = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [HDR_W-1:0]   hdr_i,
  input  logic [START_W-1:0] start_i,
  input  logic [SIZE_W-1:0]  size_i,
  output logic [HDR_W-1:0]   hdr_o,
  output logic [START_W-1:0] start_o,
  output logic [SIZE_W-1:0]  size_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_o   <= '0;
      start_o <= '0;
      size_o  <= '0;
    end else if (load) begin
      hdr_o   <= hdr_i;
      start_o <= start_i;
      size_o  <= size_i;
    end
  end
endmodule

// File: rtl/rpt_seq.sv
module rpt_seq
  import rpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  logic       c_hs,
  input  logic       p_hs,
  output rpt_state_e state,
  output logic       in_hdr,
  output logic       in_dat,
  output logic       in_cln
);
  rpt_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= rpt_next(state_q, launch, c_hs, p_hs);
  end

  assign state  = state_q;
  assign in_hdr = (state_q == ST_HDR);
  assign in_dat = (state_q == ST_DAT);
  assign in_cln = (state_q == ST_CLN);

  // R6
  cln_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_cln |=> !in_cln && !in_dat);
endmodule

// File: rtl/result_pkt_tx.sv
module result_pkt_tx
  import rpt_pkg::*;
#(
  parameter int HDR_W   = 64,
  parameter int START_W = 10,
  parameter int SIZE_W  = 11,
  parameter int PLD_W   = 32,
  parameter int USER_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               snd_req,
  input  logic [HDR_W-1:0]   snd_hdr,
  input  logic [START_W-1:0] snd_start,
  input  logic [SIZE_W-1:0]  snd_size,
  output logic [HDR_W-1:0]   ctx_tdata,
  output logic               ctx_tvalid,
  output logic               ctx_tlast,
  output logic [USER_W-1:0]  ctx_tuser,
  input  logic               ctx_tready,
  output logic [PLD_W-1:0]   pld_tdata,
  output logic               pld_tvalid,
  output logic               pld_tlast,
  input  logic               pld_tready
);
  localparam int PAD_W = PLD_W - START_W - SIZE_W;

  function automatic logic [PLD_W-1:0] pack_result(input logic [START_W-1:0] s,
                                                   input logic [SIZE_W-1:0] z);
    return {{PAD_W{1'b0}}, s, z};
  endfunction

  rpt_state_e state;
  logic in_hdr, in_dat, in_cln, idle;
  logic c_hs, p_hs, launch, use_pend, pend_load;
  logic pend_v;

  logic [HDR_W-1:0]   act_hdr, pend_hdr, src_hdr;
  logic [START_W-1:0] act_start, pend_start, src_start;
  logic [SIZE_W-1:0]  act_size, pend_size, src_size;

  assign idle = (state == ST_IDLE);
  assign c_hs = ctx_tvalid && ctx_tready;
  assign p_hs = pld_tvalid && pld_tready;

  assign use_pend  = in_cln && pend_v;
  assign launch    = (idle && snd_req) || (in_cln && (pend_v || snd_req));
  assign pend_load = snd_req && !idle && !(in_cln && !pend_v);

  assign src_hdr   = use_pend ? pend_hdr   : snd_hdr;
  assign src_start = use_pend ? pend_start : snd_start;
  assign src_size  = use_pend ? pend_size  : snd_size;

  always_ff @(posedge clk) begin
    if (!rst_n)         pend_v <= 1'b0;
    else if (pend_load) pend_v <= 1'b1;
    else if (use_pend)  pend_v <= 1'b0;
  end

  rpt_seq u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .c_hs(c_hs), .p_hs(p_hs),
    .state(state), .in_hdr(in_hdr), .in_dat(in_dat), .in_cln(in_cln)
  );

  rpt_slot #(.HDR_W(HDR_W), .START_W(START_W), .SIZE_W(SIZE_W)) u_act (
    .clk(clk), .rst_n(rst_n), .load(launch),
    .hdr_i(src_hdr), .start_i(src_start), .size_i(src_size),
    .hdr_o(act_hdr), .start_o(act_start), .size_o(act_size)
  );

  rpt_slot #(.HDR_W(HDR_W), .START_W(START_W), .SIZE_W(SIZE_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .load(pend_load),
    .hdr_i(snd_hdr), .start_i(snd_start), .size_i(snd_size),
    .hdr_o(pend_hdr), .start_o(pend_start), .size_o(pend_size)
  );

  assign ctx_tvalid = in_hdr;
  assign ctx_tlast  = in_hdr;
  assign ctx_tuser  = '0;
  assign ctx_tdata  = act_hdr;
  assign pld_tvalid = in_dat;
  assign pld_tlast  = in_dat;
  assign pld_tdata  = pack_result(act_start, act_size);

  // R2
  valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctx_tvalid && pld_tvalid));
  // R3
  ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_tvalid && !ctx_tready |=> ctx_tvalid && $stable(ctx_tdata));
  // R5
  pld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pld_tvalid && !pld_tready |=> pld_tvalid && $stable(pld_tdata));
  // R4
  pld_after_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_hs |=> pld_tvalid && !ctx_tvalid);
  // R6
  cleanup_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_hs |=> !pld_tvalid && !ctx_tvalid);
  // R8
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v && !in_cln |=> pend_v);
  // R9
  act_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_tvalid || pld_tvalid) && !in_cln |=> $stable(act_start) && $stable(act_size));
endmodule

// File: tb/tb_result_pkt_tx.sv
module tb_result_pkt_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic snd_req = 1'b0;
  logic [63:0] snd_hdr = '0;
  logic [9:0]  snd_start = '0;
  logic [10:0] snd_size = '0;
  logic [63:0] ctx_tdata;
  logic ctx_tvalid, ctx_tlast, ctx_tready;
  logic [1:0]  ctx_tuser;
  logic [31:0] pld_tdata;
  logic pld_tvalid, pld_tlast, pld_tready;

  int n_chk = 0, n_fail = 0;
  logic [63:0] q_ctx[$];
  logic [31:0] q_pld[$];
  int rdy_mode = 0;
  logic man_c = 1'b1, man_p = 1'b1;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  result_pkt_tx dut (
    .clk(clk), .rst_n(rst_n), .snd_req(snd_req), .snd_hdr(snd_hdr),
    .snd_start(snd_start), .snd_size(snd_size),
    .ctx_tdata(ctx_tdata), .ctx_tvalid(ctx_tvalid), .ctx_tlast(ctx_tlast),
    .ctx_tuser(ctx_tuser), .ctx_tready(ctx_tready),
    .pld_tdata(pld_tdata), .pld_tvalid(pld_tvalid), .pld_tlast(pld_tlast),
    .pld_tready(pld_tready)
  );

  function automatic logic [31:0] exp_word(input logic [9:0] s, input logic [10:0] z);
    logic [31:0] w;
    w = 32'd0;
    w[10:0]  = z;
    w[20:11] = s;
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ready driver
  initial begin
    ctx_tready = 1'b1;
    pld_tready = 1'b1;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (rdy_mode)
        0: begin ctx_tready = 1'b1; pld_tready = 1'b1; end
        1: begin ctx_tready = lfsr[0]; pld_tready = lfsr[5]; end
        default: begin ctx_tready = man_c; pld_tready = man_p; end
      endcase
    end
  end

  // driver: one request, optional scoreboard push, then scramble inputs (R9)
  task automatic send(input logic [63:0] h, input logic [9:0] s, input logic [10:0] z, input bit keep);
    @(negedge clk);
    snd_req = 1'b1; snd_hdr = h; snd_start = s; snd_size = z;
    if (keep) begin q_ctx.push_back(h); q_pld.push_back(exp_word(s, z)); end
    @(negedge clk);
    snd_req = 1'b0; snd_hdr = ~h; snd_start = ~s; snd_size = ~z;
  endtask

  task automatic drain();
    while (q_ctx.size() != 0 || q_pld.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: samples 5 ns after negedge, i.e. before the handshake edge
  initial begin
    forever begin
      @(negedge clk); #5;
      if (rst_n) begin
        if (ctx_tvalid && ctx_tready) begin
          if (q_ctx.size() == 0) check(0, "R8 unexpected header", ctx_tdata, 64'h0);
          else begin
            logic [63:0] e;
            e = q_ctx.pop_front();
            check(ctx_tdata == e, "R2 header data", ctx_tdata, e);
            check(ctx_tlast == 1'b1 && ctx_tuser == 2'd0, "R2 tlast/tuser",
                  {61'd0, ctx_tlast, ctx_tuser}, 64'h4);
          end
        end
        if (pld_tvalid && pld_tready) begin
          if (q_pld.size() == 0) check(0, "R8 unexpected payload", {32'd0, pld_tdata}, 64'h0);
          else begin
            logic [31:0] e;
            e = q_pld.pop_front();
            check(pld_tdata == e, "R4 payload data", {32'd0, pld_tdata}, {32'd0, e});
            check(pld_tlast == 1'b1, "R4 payload tlast", {63'd0, pld_tlast}, 64'd1);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    #(20 * 150000);
    check(0, "watchdog expired", 64'd0, 64'd1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!ctx_tvalid && !pld_tvalid, "R1 valids in reset", {62'd0, ctx_tvalid, pld_tvalid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk); #5;
    check(!ctx_tvalid && !pld_tvalid, "R1 valids after reset", {62'd0, ctx_tvalid, pld_tvalid}, 64'd0);

    // R7 latency with ready consumers, R2/R4/R6 cycle by cycle
    rdy_mode = 0;
    @(negedge clk);
    snd_req = 1'b1; snd_hdr = 64'h1111_2222_3333_4444; snd_start = 10'd5; snd_size = 11'd1024;
    q_ctx.push_back(64'h1111_2222_3333_4444); q_pld.push_back(exp_word(10'd5, 11'd1024));
    @(negedge clk); snd_req = 1'b0; snd_hdr = '0; snd_start = '0; snd_size = '0;
    #5;
    check(ctx_tvalid && !pld_tvalid, "R2 header cycle", {62'd0, ctx_tvalid, pld_tvalid}, 64'd2);
    @(negedge clk); #5;
    check(!ctx_tvalid && pld_tvalid, "R7 payload on second edge", {62'd0, ctx_tvalid, pld_tvalid}, 64'd1);
    check(pld_tdata == 32'h0000_2C00, "R4 field layout", {32'd0, pld_tdata}, 64'h2C00);
    @(negedge clk); #5;
    check(!ctx_tvalid && !pld_tvalid, "R6 cleanup cycle", {62'd0, ctx_tvalid, pld_tvalid}, 64'd0);
    drain();

    // R3 context stall, R8 requests while busy (B replaced by C)
    rdy_mode = 2; man_c = 1'b0; man_p = 1'b1;
    send(64'hAAAA_0000_0000_0001, 10'd17, 11'd3, 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #5;
      check(ctx_tvalid && !pld_tvalid && ctx_tdata == 64'hAAAA_0000_0000_0001,
            "R3 header held under stall", ctx_tdata, 64'hAAAA_0000_0000_0001);
    end
    send(64'hBBBB_0000_0000_0002, 10'd99, 11'd7, 1'b0);
    send(64'hCCCC_0000_0000_0003, 10'd1023, 11'd2047, 1'b1);
    man_c = 1'b1;
    drain();
    check(q_ctx.size() == 0, "R8 parked request sent", q_ctx.size(), 64'd0);

    // R5 payload stall
    man_c = 1'b1; man_p = 1'b0;
    send(64'hDDDD_0000_0000_0004, 10'd512, 11'd300, 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #5;
      check(pld_tvalid && !ctx_tvalid && pld_tdata == exp_word(10'd512, 11'd300),
            "R5 payload held under stall", {32'd0, pld_tdata}, {32'd0, exp_word(10'd512, 11'd300)});
    end
    man_p = 1'b1;
    drain();

    // R8 back-to-back pairs with ready consumers
    rdy_mode = 0;
    for (int i = 0; i < 4; i++) begin
      send(64'h5000 + 64'(i), 10'(i * 37), 11'(i * 101 + 1), 1'b1);
      send(64'h6000 + 64'(i), 10'(i * 53 + 2), 11'(i * 7), 1'b1);
      drain();
    end

    // R9 random backpressure, inputs scrambled after acceptance
    rdy_mode = 1;
    for (int i = 0; i < 20; i++) begin
      send({32'hFEED_0000, 32'(i)}, 10'(lfsr[9:0]), 11'(lfsr[15:5]), 1'b1);
      drain();
    end
    check(q_ctx.size() == 0 && q_pld.size() == 0, "R9 all packets seen", q_pld.size(), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule